// File: doc/BRIEF.md
# E3 Loss-of-Signal Detector

This block sits behind the line decoder of an E3 receiver. It watches the recovered serial bit stream, taking one bit on each cycle where the bit-valid strobe is high. It keeps a loss-of-signal level that software can read as a status bit. Declaring and clearing the alarm follow two different rules. A long unbroken run of zeros declares the alarm. The alarm clears only after a full observation window in which the line never shows a short zero run.

Each change of the level, in either direction, raises a single-cycle change pulse. This pulse feeds the sticky change bit of an interrupt status register, which lives outside this block. Framing, AIS detection, line decoding and register access are not part of this block.

Top module: `e3_los_detector`

## Requirements
- R1: While the alarm is inactive, 32 consecutive zeros taken on valid cycles set `los` high. The level goes high on the clock edge that takes the 32nd zero and is visible in the following cycle.
- R2: While the alarm is inactive, a one taken on a valid cycle restarts the zero count. A run of 31 zeros, or any shorter run ended by a one, leaves `los` low.
- R3: While the alarm is active, `los` falls once 32 valid bits have been taken with no run of four consecutive zeros among them. The count starts at the declaration or at the most recent four-zero run, and `los` falls on the edge that takes the 32nd such bit.
- R4: While the alarm is active, a zero run of three or fewer does not restart the observation window. The fourth consecutive zero restarts it, and so does every further zero of the same run.
- R5: The zero run that caused the declaration continues into recovery. A zero taken directly after the declaration already counts as a four-zero run and restarts the window.
- R6: `los_chg` is high for exactly one cycle, and that cycle is the first cycle in which `los` shows its new value. This holds for both the rising and the falling change. At all other times `los_chg` is low.
- R7: Cycles with `bit_vld` low advance no count and change no state, whatever `bit_in` carries.
- R8: After synchronous reset, `los` and `los_chg` are low and all run and window counts are zero. A declaration then needs a full 32-zero run.
- R9: After a release, the zero count starts from zero. A new declaration needs 32 new consecutive zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received data bit, sampled when `bit_vld` is high |
| bit_vld | input | 1 | Strobe marking a cycle that carries one line bit |
| los | output | 1 | Current loss-of-signal level (registered) |
| los_chg | output | 1 | One-cycle pulse on each change of `los` (registered) |

## Verification
A wrong run or window count shows at the ports only as a change of `los` that comes one bit early or one bit late. The bench therefore samples `los` both at the bit just before each boundary and at the boundary bit itself. A window that fails to restart, or a zero run that does not carry across the declaration, shows up as a release 1 to 4 bits too soon. The corner tests place a single zero or a three-zero run just before the window ends to expose this. A stuck or doubled change pulse is visible in the cycle after every change of the level.

// File: rtl/e3_los_pkg.sv
package e3_los_pkg;
  // width needed to hold values 0..max inclusive
  function automatic int cnt_w(input int max);
    return (max < 1) ? 1 : $clog2(max + 1);
  endfunction
endpackage

// File: rtl/e3_los_run_counter.sv
module e3_los_run_counter
  import e3_los_pkg::*;
#(
  parameter int MAX = 32,
  localparam int W = cnt_w(MAX)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         preset,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] MAXV = W'(MAX);

  // saturating up-counter; preset loads the ceiling
  always_ff @(posedge clk) begin
    if (rst)                       count <= '0;
    else if (preset)               count <= MAXV;
    else if (clr)                  count <= '0;
    else if (inc && count != MAXV) count <= count + 1'b1;
  end

  // R8: never beyond its ceiling
  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= MAXV);

  // R7: without inc, preset or clr the count holds
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !preset && !clr) |=> $stable(count));
endmodule

// File: rtl/e3_los_state.sv
module e3_los_state (
  input  logic clk,
  input  logic rst,
  input  logic decl,
  input  logic rel,
  output logic los,
  output logic los_chg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      los     <= 1'b0;
      los_chg <= 1'b0;
    end else begin
      los_chg <= decl | rel;
      if (decl)     los <= 1'b1;
      else if (rel) los <= 1'b0;
    end
  end

  // R6: pulse exactly when the level has just changed
  a_r6_chg_on_edge: assert property (@(posedge clk) disable iff (rst)
    (los != $past(los)) |-> los_chg);
  a_r6_chg_only_edge: assert property (@(posedge clk) disable iff (rst)
    los_chg |-> (los != $past(los)));
endmodule

// File: rtl/e3_los_detector.sv
module e3_los_detector
  import e3_los_pkg::*;
#(
  parameter int DECL_RUN  = 32,
  parameter int WIN_LEN   = 32,
  parameter int SHORT_RUN = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic los,
  output logic los_chg
);
  localparam int ZW = cnt_w(DECL_RUN);
  localparam int SW = cnt_w(SHORT_RUN);
  localparam int WW = cnt_w(WIN_LEN);
  localparam logic [ZW-1:0] Z_LAST = ZW'(DECL_RUN - 1);
  localparam logic [SW-1:0] S_LAST = SW'(SHORT_RUN - 1);
  localparam logic [WW-1:0] W_LAST = WW'(WIN_LEN - 1);

  logic [ZW-1:0] zrun;
  logic [SW-1:0] srun;
  logic [WW-1:0] wcnt;
  logic zero_bit, one_bit, decl, restart, rel;

  assign zero_bit = bit_vld & ~bit_in;
  assign one_bit  = bit_vld &  bit_in;

  // declaration: long zero run while clear
  assign decl    = ~los & zero_bit & (zrun == Z_LAST);
  // recovery: short zero run restarts window, full window releases
  assign restart = los & zero_bit & (srun >= S_LAST);
  assign rel     = los & bit_vld & ~restart & (wcnt == W_LAST);

  e3_los_run_counter #(.MAX(DECL_RUN)) u_zrun (
    .clk(clk), .rst(rst),
    .preset(1'b0),
    .clr(los | one_bit),
    .inc(zero_bit),
    .count(zrun)
  );

  // preset at declaration: the line ended on a zero run
  e3_los_run_counter #(.MAX(SHORT_RUN)) u_srun (
    .clk(clk), .rst(rst),
    .preset(decl),
    .clr(~los | one_bit),
    .inc(los & zero_bit),
    .count(srun)
  );

  e3_los_run_counter #(.MAX(WIN_LEN)) u_win (
    .clk(clk), .rst(rst),
    .preset(1'b0),
    .clr(~los | restart),
    .inc(los & bit_vld),
    .count(wcnt)
  );

  e3_los_state u_state (
    .clk(clk), .rst(rst),
    .decl(decl), .rel(rel),
    .los(los), .los_chg(los_chg)
  );

  // R1: rise only after a valid zero
  a_r1_rise_on_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> ($past(bit_vld) && !$past(bit_in)));
  // R7: no valid bit, no change
  a_r7_idle_no_chg: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> !los_chg);
  // R3: release only on a valid bit
  a_r3_fall_on_valid: assert property (@(posedge clk) disable iff (rst)
    $fell(los) |-> $past(bit_vld));
  // R4: a restart empties the window
  a_r4_restart_clears: assert property (@(posedge clk) disable iff (rst)
    restart |=> (wcnt == '0));
endmodule

// File: tb/e3_los_detector_tb.sv
module e3_los_detector_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic los, los_chg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  e3_los_detector u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld),
    .los(los), .los_chg(los_chg)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  // drive one valid bit; returns 5 ns after the edge that took it
  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b1;
    @(posedge clk); #5;
  endtask

  task automatic send_n(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
  endtask

  task automatic idle(input int n, input logic b);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_in = b; bit_vld = 1'b0;
      @(posedge clk); #5;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic declare_los();
    send_n(1'b0, 32);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R8 los after reset", los, 1'b0);
    chk("R8 chg after reset", los_chg, 1'b0);
    send_n(1'b0, 31);
    chk("R8 31 zeros from reset", los, 1'b0);
  endtask

  task automatic t_declare();
    do_reset();
    send_n(1'b0, 31);
    chk("R1 no los at 31", los, 1'b0);
    chk("R6 no chg at 31", los_chg, 1'b0);
    send_bit(1'b0);
    chk("R1 los at 32", los, 1'b1);
    chk("R6 chg on rise", los_chg, 1'b1);
    send_bit(1'b1);
    chk("R6 chg one cycle", los_chg, 1'b0);
  endtask

  task automatic t_broken_run();
    do_reset();
    send_n(1'b0, 20);
    send_bit(1'b1);
    send_n(1'b0, 31);
    chk("R2 one restarts run", los, 1'b0);
    send_bit(1'b0);
    chk("R2 full run after one", los, 1'b1);
  endtask

  task automatic t_invalid();
    do_reset();
    send_n(1'b0, 31);
    idle(40, 1'b1);
    chk("R7 idle ones ignored", los, 1'b0);
    send_bit(1'b0);
    chk("R7 run kept across idle", los, 1'b1);
    idle(10, 1'b0);
    chk("R7 idle keeps los", los, 1'b1);
    chk("R7 idle no chg", los_chg, 1'b0);
  endtask

  task automatic t_release_ones();
    do_reset();
    declare_los();
    send_n(1'b1, 31);
    chk("R3 los at 31 ones", los, 1'b1);
    idle(5, 1'b1);
    send_bit(1'b1);
    chk("R3 release at 32", los, 1'b0);
    chk("R6 chg on fall", los_chg, 1'b1);
    idle(1, 1'b0);
    chk("R6 fall pulse one cycle", los_chg, 1'b0);
  endtask

  task automatic t_short_runs();
    do_reset();
    declare_los();
    send_bit(1'b1);
    for (int i = 0; i < 7; i++) begin
      send_n(1'b0, 3);
      send_bit(1'b1);
    end
    send_n(1'b0, 2);
    chk("R4 three-zero runs at 31", los, 1'b1);
    send_bit(1'b0);
    chk("R4 three-zero runs release", los, 1'b0);
  endtask

  task automatic t_restart();
    do_reset();
    declare_los();
    send_n(1'b1, 20);
    send_n(1'b0, 4);
    send_n(1'b1, 31);
    chk("R4 restart holds at 31", los, 1'b1);
    send_bit(1'b1);
    chk("R4 release 32 after restart", los, 1'b0);
  endtask

  task automatic t_carry();
    do_reset();
    declare_los();
    send_bit(1'b0);
    send_n(1'b1, 31);
    chk("R5 carried run restarts", los, 1'b1);
    send_bit(1'b1);
    chk("R5 release after carry", los, 1'b0);
  endtask

  task automatic t_rearm();
    do_reset();
    declare_los();
    send_n(1'b1, 32);
    chk("R9 released", los, 1'b0);
    send_n(1'b0, 31);
    chk("R9 fresh count at 31", los, 1'b0);
    send_bit(1'b0);
    chk("R9 redeclare at 32", los, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_declare();
    t_broken_run();
    t_invalid();
    t_release_ones();
    t_short_runs();
    t_restart();
    t_carry();
    t_rearm();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule